// File: doc/BRIEF.md
# Masked-Write CAM Command Unit

This block is a small content-addressable memory: a set of data entries, each with a validity flag. A command unit in front of it runs one command per clock. Each command is given by a strobe level, a 6-bit operation field, a mask-select field, a data word and an active-low validity input. The commands write a word into the first empty entry, rewrite the entry that won the last search, read that winning entry, read the entry that an address pointer selects and then step the pointer down, read and write the pointer, and report where the next free write will land. A compare command searches the valid entries for a key and keeps the result as a match vector.

Every write to an entry or to the pointer can be filtered through one of seven mask registers. Only bit positions where the chosen mask holds 0 take the new value. Read results come out of a register one cycle after the command, together with an output-enable flag. The flag stays low when there is nothing to return. This stands in for an output that is not driven.

Entry priority is by index: a lower index beats a higher one, both for the search winner and for the free slot. The entry count must be a power of two, so that the pointer wraps cleanly.

Top module: `cam_cmd_unit`

## Requirements
- R1: While reset is low, and on the cycle after it, `data_oe` is 0. Reset leaves every entry empty, the pointer at 0, every mask register all zeros and the match vector clear.
- R2: With `wr_n`=0 and `op`=0x02, the data is written into the lowest-index empty entry. That entry's validity becomes valid when `vld_n_in`=0 and empty when `vld_n_in`=1.
- R3: A mask select of 0 writes all bits. A nonzero select N applies mask register N, and only bits where that register holds 0 are changed. This holds for every entry write and for pointer writes.
- R4: With `wr_n`=0 and `op`=0x04, `data_in` is loaded into mask register `msel` when `msel` is 1 to 7. When `msel` is 0 the command changes nothing.
- R5: With `op`=0x05, whatever the strobe level, the match vector is set to valid entries whose bits equal `data_in` in every position where the selected mask holds 0. The vector is held until the next compare or any write command (`wr_n`=0 with `op` 0x01 to 0x04).
- R6: With `wr_n`=1 and `op`=0x01, the lowest-index matching entry is returned, with `rd_vld_n` set to the inverse of its validity. If nothing matches, `data_oe` stays 0.
- R7: With `wr_n`=0 and `op`=0x01, the lowest-index matching entry is rewritten through the mask, and its validity is taken from `vld_n_in`. If nothing matches, no entry changes.
- R8: With `wr_n`=1 and `op`=0x04, the entry at the pointer is returned, with `rd_vld_n` set to the inverse of its validity, whether the entry is valid or empty. The pointer then decrements, wrapping from 0 to the top entry.
- R9: With `wr_n`=0 and `op`=0x03, the pointer is written from the low bits of `data_in` through the mask. With `wr_n`=1 and `op`=0x03, the pointer is returned zero-extended.
- R10: With `wr_n`=1 and `op`=0x02, the result word holds the free entry index in bits 11:0, `PAGE_ID` in bits 15:12 and zeros in bits 31:16. When all entries are valid, `data_oe` stays 0 and a write to the next free entry is ignored.
- R11: `op`=0x00, and any op value from 0x06 to 0x3F, leaves the entries, the pointer, the mask registers and the match vector unchanged.
- R12: A read result appears in the cycle after its command, and `data_oe` is high for exactly that one cycle. When `data_oe` is 0, `rd_vld_n` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Strobe level: 0 selects the write form of the op, 1 the read form |
| op | input | 6 | Operation field |
| msel | input | SEL_W | Mask register select (0 = none) |
| data_in | input | W | Write data, compare key or mask value |
| vld_n_in | input | 1 | Validity for entry writes, active low |
| data_out | output | W | Registered read result |
| data_oe | output | 1 | High when data_out carries a result |
| rd_vld_n | output | 1 | Inverse validity of the entry just read |

## Verification
The state that can go wrong is the match vector, the validity flags, the pointer and the mask registers. None of these is visible directly. Each one shows up at the ports on the next read that uses it. A stale or wrongly cleared match vector shows as an enable that is present or missing on the following winner read. A pointer that is off by one shows as the wrong word on the next indirect read. A mask bit in the wrong place shows as a corrupted field in a later read-back of the entry. The bench therefore follows every kind of write with a read that exposes its result, so that any fault surfaces within a few cycles.

// File: rtl/cam_pkg.sv
// Shared operation codes for the CAM command unit.
// Assumes a 6-bit operation field; unlisted codes are no-operations.
package cam_pkg;
    localparam int OP_W = 6;
    localparam logic [OP_W-1:0] OP_NOP  = 6'h00;
    localparam logic [OP_W-1:0] OP_HPM  = 6'h01;  // winner read / winner write
    localparam logic [OP_W-1:0] OP_NFA  = 6'h02;  // free address read / free write
    localparam logic [OP_W-1:0] OP_AREG = 6'h03;  // pointer read / pointer write
    localparam logic [OP_W-1:0] OP_IND  = 6'h04;  // indirect read / mask load
    localparam logic [OP_W-1:0] OP_CMP  = 6'h05;  // compare, either strobe level
endpackage

// File: rtl/cam_prio_enc.sv
// Lowest-index-first priority encoder.
// Assumes N >= 2; idx is 0 when hit is low.
module cam_prio_enc #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cam_mask_bank.sv
// Bank of write/compare mask registers; select 0 is a fixed all-zero mask.
// Assumes a load with select 0 has already been filtered out by the caller.
module cam_mask_bank #(
    parameter int W     = 32,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [W-1:0]     ld_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [W-1:0]     mask
);
    localparam int NUM = 1 << SEL_W;

    logic [W-1:0] bank_q [NUM];

    // Hold the mask registers; slot 0 is never written and stays zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) bank_q[i] <= '0;
        end else begin
            for (int i = 1; i < NUM; i++) begin
                if (ld_en && ld_sel == SEL_W'(i)) bank_q[i] <= ld_data;
            end
        end
    end

    // Pick the active mask; select 0 means no protection.
    always_comb mask = (rd_sel == '0) ? '0 : bank_q[rd_sel];
endmodule

// File: rtl/cam_array.sv
// Storage of the CAM entries with their validity flags and match vector.
// Assumes write and compare never coincide; a write clears the match vector.
module cam_array #(
    parameter int ENTRIES = 16,
    parameter int W       = 32,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [W-1:0]       wr_mask,
    input  logic [W-1:0]       wr_data,
    input  logic               wr_valid,
    input  logic               cmp_en,
    input  logic [W-1:0]       cmp_key,
    input  logic [W-1:0]       cmp_mask,
    input  logic               clr_match,
    input  logic [AW-1:0]      rd_idx,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] match_vec,
    output logic [W-1:0]       rd_data,
    output logic               rd_valid
);
    logic [W-1:0] ent_data [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [W-1:0] data_q;
        logic         valid_q;
        logic         match_q;

        // Masked update of one entry and its validity flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q  <= '0;
                valid_q <= 1'b0;
            end else if (wr_en && wr_idx == AW'(g)) begin
                data_q  <= (data_q & wr_mask) | (wr_data & ~wr_mask);
                valid_q <= wr_valid;
            end
        end

        // Match flag: set by compare over valid entries, dropped by writes.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_match) match_q <= 1'b0;
            else if (cmp_en)         match_q <= valid_q && (((data_q ^ cmp_key) & ~cmp_mask) == '0);
        end

        assign ent_data[g]  = data_q;
        assign valid_vec[g] = valid_q;
        assign match_vec[g] = match_q;
    end

    // Single read port shared by winner reads and indirect reads.
    always_comb begin
        rd_data  = ent_data[rd_idx];
        rd_valid = valid_vec[rd_idx];
    end
endmodule

// File: rtl/cam_cmd_unit.sv
// Command front end of the masked-write CAM: decodes strobe level and op,
// steers masked writes, keeps the address pointer and registers read results.
// Assumes ENTRIES is a power of two no larger than 4096 and W >= 16.
module cam_cmd_unit #(
    parameter int         ENTRIES = 16,
    parameter int         W       = 32,
    parameter int         SEL_W   = 3,
    parameter logic [3:0] PAGE_ID = 4'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic [5:0]       op,
    input  logic [SEL_W-1:0] msel,
    input  logic [W-1:0]     data_in,
    input  logic             vld_n_in,
    output logic [W-1:0]     data_out,
    output logic             data_oe,
    output logic             rd_vld_n
);
    import cam_pkg::*;

    localparam int AW    = $clog2(ENTRIES);
    localparam int IDX_W = 12;

    logic [AW-1:0]      ar_q;
    logic [ENTRIES-1:0] valid_vec, match_vec;
    logic [W-1:0]       sel_mask, rd_data;
    logic               rd_valid;
    logic               hpm_hit, free_hit;
    logic [AW-1:0]      hpm_idx, free_idx, rd_idx, wr_idx;
    logic               rd_hpm, wr_hpm, rd_nfa, wr_nfa, rd_ar, wr_ar;
    logic               rd_ind, mload, do_cmp, any_wr, arr_wr;

    // Decode strobe level and op field into one-hot command strobes.
    always_comb begin
        rd_hpm = 1'b0; wr_hpm = 1'b0; rd_nfa = 1'b0; wr_nfa = 1'b0;
        rd_ar  = 1'b0; wr_ar  = 1'b0; rd_ind = 1'b0; mload  = 1'b0;
        do_cmp = 1'b0; any_wr = 1'b0;
        case (op)
            OP_HPM:  begin rd_hpm = wr_n; wr_hpm = !wr_n; any_wr = !wr_n; end
            OP_NFA:  begin rd_nfa = wr_n; wr_nfa = !wr_n; any_wr = !wr_n; end
            OP_AREG: begin rd_ar  = wr_n; wr_ar  = !wr_n; any_wr = !wr_n; end
            OP_IND:  begin rd_ind = wr_n; mload  = !wr_n && (msel != '0); any_wr = !wr_n; end
            OP_CMP:  do_cmp = 1'b1;
            default: ;
        endcase
    end

    // Steer the array write to the winner or the free slot.
    always_comb begin
        arr_wr = (wr_hpm && hpm_hit) || (wr_nfa && free_hit);
        wr_idx = wr_hpm ? hpm_idx : free_idx;
        rd_idx = rd_hpm ? hpm_idx : ar_q;
    end

    cam_mask_bank #(.W(W), .SEL_W(SEL_W)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (mload),
        .ld_sel  (msel),
        .ld_data (data_in),
        .rd_sel  (msel),
        .mask    (sel_mask)
    );

    cam_array #(.ENTRIES(ENTRIES), .W(W), .AW(AW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (arr_wr),
        .wr_idx    (wr_idx),
        .wr_mask   (sel_mask),
        .wr_data   (data_in),
        .wr_valid  (!vld_n_in),
        .cmp_en    (do_cmp),
        .cmp_key   (data_in),
        .cmp_mask  (sel_mask),
        .clr_match (any_wr),
        .rd_idx    (rd_idx),
        .valid_vec (valid_vec),
        .match_vec (match_vec),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    cam_prio_enc #(.N(ENTRIES), .IW(AW)) u_win (
        .req (match_vec),
        .hit (hpm_hit),
        .idx (hpm_idx)
    );

    cam_prio_enc #(.N(ENTRIES), .IW(AW)) u_free (
        .req (~valid_vec),
        .hit (free_hit),
        .idx (free_idx)
    );

    // Address pointer: masked load or post-decrement on indirect read.
    always_ff @(posedge clk) begin
        if (!rst_n)      ar_q <= '0;
        else if (wr_ar)  ar_q <= (ar_q & sel_mask[AW-1:0]) | (data_in[AW-1:0] & ~sel_mask[AW-1:0]);
        else if (rd_ind) ar_q <= ar_q - 1'b1;
    end

    // Register the read result and its enable for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_oe  <= 1'b0;
            data_out <= '0;
            rd_vld_n <= 1'b1;
        end else begin
            data_oe  <= 1'b0;
            data_out <= '0;
            rd_vld_n <= 1'b1;
            if ((rd_hpm && hpm_hit) || rd_ind) begin
                data_oe  <= 1'b1;
                data_out <= rd_data;
                rd_vld_n <= !rd_valid;
            end else if (rd_nfa && free_hit) begin
                data_oe  <= 1'b1;
                data_out <= {{(W-16){1'b0}}, PAGE_ID, {(IDX_W-AW){1'b0}}, free_idx};
            end else if (rd_ar) begin
                data_oe  <= 1'b1;
                data_out <= {{(W-AW){1'b0}}, ar_q};
            end
        end
    end
endmodule

// File: rtl/cam_cmd_unit_chk.sv
// Temporal checks on the CAM command unit, bound into every instance.
// Assumes the opcode values of cam_pkg.
module cam_cmd_unit_chk #(
    parameter int ENTRIES = 16,
    parameter int AW      = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_n,
    input logic [5:0]         op,
    input logic               data_oe,
    input logic [AW-1:0]      ar_q,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] match_vec
);
    import cam_pkg::*;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!data_oe && valid_vec == '0 && match_vec == '0));

    a_r12_oe_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(wr_n && (op == OP_HPM || op == OP_NFA || op == OP_AREG || op == OP_IND)));

    a_r6_no_match_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && op == OP_HPM && match_vec == '0) |=> !data_oe);

    a_r8_pointer_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && op == OP_IND) |=> (ar_q == AW'($past(ar_q) - 1'b1)));

    a_r11_nop_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP) |=> ($stable(ar_q) && $stable(valid_vec) && $stable(match_vec)));

    a_r5_match_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ~valid_vec) == '0);
endmodule

bind cam_cmd_unit cam_cmd_unit_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .op        (op),
    .data_oe   (data_oe),
    .ar_q      (ar_q),
    .valid_vec (valid_vec),
    .match_vec (match_vec)
);

// File: tb/tb_cam_cmd_unit.sv
// Scoreboard bench: the driver updates a behavioural model and queues the
// expected read result; the monitor compares each cycle at the falling edge.
module tb_cam_cmd_unit;
    localparam logic [5:0] NOP = 6'h00, HPM = 6'h01, NFA = 6'h02, AREG = 6'h03, IND = 6'h04, CMP = 6'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [5:0]  op = NOP;
    logic [2:0]  msel = '0;
    logic [31:0] data_in = '0;
    logic        vld_n_in = 1'b1;
    logic [31:0] data_out;
    logic        data_oe;
    logic        rd_vld_n;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [31:0] m_mem [16];
    bit          m_val [16];
    bit          m_match [16];
    logic [31:0] m_mreg [8];
    logic [3:0]  m_ar;

    int          q_cyc [$];
    bit          q_oe [$];
    logic [31:0] q_data [$];
    bit          q_vn [$];
    string       q_tag [$];

    cam_cmd_unit #(.ENTRIES(16), .W(32), .SEL_W(3), .PAGE_ID(4'h5)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .op(op), .msel(msel),
        .data_in(data_in), .vld_n_in(vld_n_in),
        .data_out(data_out), .data_oe(data_oe), .rd_vld_n(rd_vld_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input bit oe, input logic [31:0] d, input bit vn, input string tag);
        q_cyc.push_back(cyc + 1);
        q_oe.push_back(oe);
        q_data.push_back(oe ? d : 32'h0);
        q_vn.push_back(oe ? vn : 1'b1);
        q_tag.push_back(tag);
    endtask

    // Drive one command, update the model and queue any expected result.
    task automatic cmd(input bit w, input logic [5:0] o, input logic [2:0] ms,
                       input logic [31:0] d, input bit vn, input string tag);
        logic [31:0] m;
        int hp, fr;
        @(negedge clk);
        wr_n = w; op = o; msel = ms; data_in = d; vld_n_in = vn;
        m = (ms == 0) ? 32'h0 : m_mreg[ms];
        hp = -1; fr = -1;
        for (int i = 15; i >= 0; i--) begin
            if (m_match[i]) hp = i;
            if (!m_val[i]) fr = i;
        end
        if (o == CMP) begin
            for (int i = 0; i < 16; i++) m_match[i] = m_val[i] && (((m_mem[i] ^ d) & ~m) == 0);
        end else if (w && o == HPM) begin
            if (hp >= 0) push(1, m_mem[hp], !m_val[hp], tag); else push(0, 0, 1, tag);
        end else if (w && o == NFA) begin
            if (fr >= 0) push(1, {16'h0, 4'h5, 8'h0, 4'(fr)}, 1, tag); else push(0, 0, 1, tag);
        end else if (w && o == AREG) begin
            push(1, {28'h0, m_ar}, 1, tag);
        end else if (w && o == IND) begin
            push(1, m_mem[m_ar], !m_val[m_ar], tag);
            m_ar = m_ar - 1;
        end else if (!w && o >= HPM && o <= IND) begin
            if (o == HPM && hp >= 0) begin
                m_mem[hp] = (m_mem[hp] & m) | (d & ~m); m_val[hp] = !vn;
            end else if (o == NFA && fr >= 0) begin
                m_mem[fr] = (m_mem[fr] & m) | (d & ~m); m_val[fr] = !vn;
            end else if (o == AREG) begin
                m_ar = (m_ar & m[3:0]) | (d[3:0] & ~m[3:0]);
            end else if (o == IND && ms != 0) begin
                m_mreg[ms] = d;
            end
            for (int i = 0; i < 16; i++) m_match[i] = 0;
        end
    endtask

    // Monitor: pop the queued result due this cycle, else expect no enable.
    initial begin
        forever begin
            @(negedge clk);
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                chk(data_oe === q_oe[0], {q_tag[0], " oe"}, {31'h0, data_oe}, {31'h0, q_oe[0]});
                if (q_oe[0]) begin
                    chk(data_out === q_data[0], {q_tag[0], " data"}, data_out, q_data[0]);
                    chk(rd_vld_n === q_vn[0], {q_tag[0], " vld_n"}, {31'h0, rd_vld_n}, {31'h0, q_vn[0]});
                end else begin
                    chk(rd_vld_n === 1'b1, {q_tag[0], " R12 idle vld_n"}, {31'h0, rd_vld_n}, 32'h1);
                end
                void'(q_cyc.pop_front()); void'(q_oe.pop_front()); void'(q_data.pop_front());
                void'(q_vn.pop_front()); void'(q_tag.pop_front());
            end else begin
                chk(data_oe === 1'b0, rst_n ? "R12 no read, oe low" : "R1 oe low in reset",
                    {31'h0, data_oe}, 32'h0);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL R12 watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_mem[i] = 0; m_val[i] = 0; m_match[i] = 0; end
        for (int i = 0; i < 8; i++) m_mreg[i] = 0;
        m_ar = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cmd(1, AREG, 0, 0, 1, "R1 pointer zero after reset");
        cmd(1, NFA, 0, 0, 1, "R1 R10 free index zero with page");
        cmd(1, IND, 0, 0, 1, "R8 indirect read of empty entry");
        cmd(1, AREG, 0, 0, 1, "R8 pointer wrapped to top");
        cmd(0, NFA, 0, 32'h1111_AAAA, 0, "R2 write free");
        cmd(0, NFA, 0, 32'h2222_AAAA, 0, "R2 write free");
        cmd(0, NFA, 0, 32'h0000_00C2, 1, "R2 write free as empty");
        cmd(1, NFA, 0, 0, 1, "R2 R10 empty write keeps slot free");
        cmd(0, IND, 3, 32'hFFFF_0000, 1, "R4 load mask 3");
        cmd(0, IND, 0, 32'hFFFF_FFFF, 1, "R4 select 0 load ignored");
        cmd(0, AREG, 0, 32'h1, 1, "R9 unmasked pointer write");
        cmd(1, IND, 0, 0, 1, "R8 R2 read entry 1 valid");
        cmd(1, CMP, 0, 32'h1111_AAAA, 1, "R5 exact compare");
        cmd(1, HPM, 0, 0, 1, "R6 winner read entry 0");
        cmd(1, CMP, 3, 32'h9999_AAAA, 1, "R5 masked compare");
        cmd(1, HPM, 0, 0, 1, "R6 lowest index wins");
        cmd(0, NOP, 0, 32'h1234_5678, 0, "R11 nop");
        cmd(1, 6'h3F, 0, 32'h1234_5678, 0, "R11 unassigned op");
        cmd(1, HPM, 0, 0, 1, "R5 R11 match held");
        cmd(0, HPM, 3, 32'h3333_5555, 0, "R7 R3 masked winner write");
        cmd(1, HPM, 0, 0, 1, "R5 R6 write cleared match");
        cmd(1, IND, 0, 0, 1, "R3 masked bits kept");
        cmd(1, CMP, 0, 32'h0000_00C2, 1, "R5 empty entry excluded");
        cmd(1, HPM, 0, 0, 1, "R6 no match no oe");
        cmd(0, HPM, 0, 32'hDEAD_BEEF, 0, "R7 write with no match");
        cmd(0, AREG, 0, 32'h2, 1, "R9 point at entry 2");
        cmd(1, IND, 0, 0, 1, "R7 entry 2 untouched");
        cmd(0, IND, 5, 32'h0000_0003, 1, "R4 load mask 5");
        cmd(0, AREG, 5, 32'h0000_000C, 1, "R9 R3 masked pointer write");
        cmd(1, AREG, 0, 0, 1, "R9 pointer read back");
        for (int i = 0; i < 14; i++) cmd(0, NFA, 0, 32'h5000_0000 + i, 0, "R2 fill");
        cmd(1, NFA, 0, 0, 1, "R10 full gives no oe");
        cmd(0, NFA, 0, 32'hFFFF_FFFF, 0, "R10 write when full");
        cmd(1, CMP, 0, 32'hFFFF_FFFF, 1, "R10 compare for ignored word");
        cmd(1, HPM, 0, 0, 1, "R10 ignored write not stored");
        cmd(1, CMP, 0, 32'h5000_0003, 1, "R5 compare fill word");
        cmd(1, HPM, 0, 0, 1, "R6 fill word found");
        cmd(0, NOP, 0, 0, 1, "R12 idle");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule